// File: doc/BRIEF.md
# Return-Address Stack with Interrupt-Acknowledge Gating

This block keeps the return addresses of a small processor core in a last-in, first-out store of eight 12-bit entries. A subroutine call or an accepted interrupt writes the current return address on top; a return, whether from a subroutine or from an interrupt routine, takes the top entry off and presents it, one clock later, as the address to resume from. The pointer and the entries are hidden: nothing outside the block can read or write them except through push and pop.

The block also sits between the interrupt controller and the core. An enabled request that is already latched upstream reaches the block as a level. The block grants it only while a level is free and no call or return is in progress in that cycle. A full stack therefore holds requests back until a return frees a level. A call, in contrast, is never refused. When the stack is full, the call overwrites the oldest entry and sets a sticky overflow flag. Popping an empty stack, or asking for a push and a pop in the same cycle, is recorded in its own sticky flag.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty (`empty_o`=1, `full_o`=0), `ret_addr_o` is 0 and the three sticky flags are 0.
- R2: A push stores `ret_pc_i`. A pop presents the most recently pushed entry that has not yet been popped on `ret_addr_o` from the clock edge that takes it, so entries come back in reverse order of pushing.
- R3: `irq_ack_o` is 1 exactly when `irq_req_i` is 1, the stack is not full, and neither `call_i` nor `ret_i` is 1 in that cycle. An acknowledge pushes `ret_pc_i` just like a call.
- R4: `full_o` is 1 when eight entries are held and `empty_o` is 1 when none are held. The occupancy never exceeds eight.
- R5: A call while full still pushes. The write position wraps, so the oldest entry is overwritten, and the occupancy stays at eight. `overflow_o` becomes 1 and stays 1 until reset.
- R6: A pop while empty leaves `ret_addr_o` and the occupancy unchanged. `underflow_o` becomes 1 and stays 1 until reset.
- R7: A push and a pop in the same cycle perform only the push: the pop is dropped and `ret_addr_o` keeps its value. `collide_o` becomes 1 and stays 1 until reset.
- R8: A request held back by a full stack is acknowledged in the first cycle after a pop has freed a level, provided it is still requested and no call or return is present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call: push request |
| ret_i | input | 1 | Return or return-from-interrupt: pop request |
| irq_req_i | input | 1 | Latched, enabled interrupt request (level) |
| ret_pc_i | input | 12 | Return address to push |
| irq_ack_o | output | 1 | Interrupt acknowledge (combinational), pushes when 1 |
| ret_addr_o | output | 12 | Restore address from the last successful pop |
| full_o | output | 1 | All levels in use |
| empty_o | output | 1 | No level in use |
| overflow_o | output | 1 | Sticky: a push happened while full |
| underflow_o | output | 1 | Sticky: a pop happened while empty |
| collide_o | output | 1 | Sticky: push and pop requested together |

## Verification
Directed sequences come first. Nested pushes followed by the same number of pops show whether the order is last-in first-out and whether the pointer comes back to empty. A burst of calls past the eighth level separates wrap-and-overwrite from a refused push. A steady interrupt request across a fill and a single pop shows whether the acknowledge is held back and then released. Pops on an empty stack and simultaneous call-and-return show that the restore address stays put while only the matching sticky flag rises. A seeded random mix of calls, returns and requests at changing densities then keeps the stack at every occupancy, including long stretches near full and near empty.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Circular index arithmetic, kept here so the bench can restate it independently.
  function automatic int unsigned idx_next(input int unsigned p, input int unsigned d);
    return (p == d - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned idx_prev(input int unsigned p, input int unsigned d);
    return (p == 0) ? d - 1 : p - 1;
  endfunction
endpackage

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic call_i,
  input  logic ret_i,
  input  logic irq_req_i,
  input  logic full_i,
  output logic ack_o,
  output logic push_o,
  output logic pop_o,
  output logic clash_o
);
  // A grant needs a free level and a cycle with no call or return of its own.
  assign ack_o   = irq_req_i & ~full_i & ~call_i & ~ret_i;
  assign push_o  = call_i | ack_o;
  assign pop_o   = ret_i;
  assign clash_o = push_o & pop_o;

  p_no_ack_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |-> !ack_o);
  p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (irq_req_i && !call_i && !ret_i));
endmodule

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o,
  output logic          rd_en_o,
  output logic [PW-1:0] rd_idx_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          col_o
);
  import ras_pkg::*;

  logic [PW-1:0] wp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_ev, unf_ev, col_ev;

  assign full_o   = (cnt_q == CW'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign wr_en_o  = push_i;
  assign wr_idx_o = wp_q;
  assign rd_idx_o = PW'(idx_prev(int'(wp_q), DEPTH));
  assign rd_en_o  = pop_i & ~push_i & ~empty_o;

  // Named events for the checks
  assign ovf_ev = push_i & full_o;
  assign unf_ev = pop_i & ~push_i & empty_o;
  assign col_ev = push_i & pop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      col_o <= 1'b0;
    end else begin
      if (push_i) begin
        wp_q <= PW'(idx_next(int'(wp_q), DEPTH));
        if (!full_o) cnt_q <= cnt_q + 1'b1;
      end else if (rd_en_o) begin
        wp_q  <= rd_idx_o;
        cnt_q <= cnt_q - 1'b1;
      end
      if (ovf_ev) ovf_o <= 1'b1;
      if (unf_ev) unf_o <= 1'b1;
      if (col_ev) col_o <= 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_push_leaves_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && empty_o) |=> !empty_o);
  p_ovf_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (full_o && ovf_o));
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  p_unf_stays_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev |=> (empty_o && unf_o));
  p_col_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_ev |=> col_o);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 12,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PW'(g))     slot_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= slot_q[rd_idx_i];
  end

  p_hold_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 12,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_req_i,
  input  logic [AW-1:0] ret_pc_i,
  output logic          irq_ack_o,
  output logic [AW-1:0] ret_addr_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          overflow_o,
  output logic          underflow_o,
  output logic          collide_o
);
  logic          push_w, pop_w, clash_w;
  logic          wr_en_w, rd_en_w;
  logic [PW-1:0] wr_idx_w, rd_idx_w;

  ras_irq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .irq_req_i (irq_req_i),
    .full_i    (full_o),
    .ack_o     (irq_ack_o),
    .push_o    (push_w),
    .pop_o     (pop_w),
    .clash_o   (clash_w)
  );

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (push_w),
    .pop_i    (pop_w),
    .wr_en_o  (wr_en_w),
    .wr_idx_o (wr_idx_w),
    .rd_en_o  (rd_en_w),
    .rd_idx_o (rd_idx_w),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .ovf_o    (overflow_o),
    .unf_o    (underflow_o),
    .col_o    (collide_o)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_w),
    .wr_idx_i  (wr_idx_w),
    .wr_data_i (ret_pc_i),
    .rd_en_i   (rd_en_w),
    .rd_idx_i  (rd_idx_w),
    .rd_data_o (ret_addr_o)
  );

  p_clash_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash_w |=> $stable(ret_addr_o));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && ret_i && !call_i) |=> !full_o);
endmodule

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/1ps
module ret_addr_stack_tb;
  localparam int D = 8;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic call_i = 0, ret_i = 0, irq_req_i = 0;
  logic [W-1:0] ret_pc_i = '0;
  logic irq_ack_o, full_o, empty_o, overflow_o, underflow_o, collide_o;
  logic [W-1:0] ret_addr_o;

  always #2.5 clk = ~clk;

  ret_addr_stack u_dut (.*);

  int checks = 0, errors = 0;
  // Reference model
  logic [W-1:0] mm [D];
  int mwp, mcnt;
  logic [W-1:0] mret;
  bit movf, munf, mcol;

  function automatic int nxt(int p); return (p + 1) % D; endfunction
  function automatic int prv(int p); return (p + D - 1) % D; endfunction
  function automatic bit exp_ack(bit c, bit r, bit q, int cnt);
    return q && (cnt < D) && !c && !r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " ret_addr"}, ret_addr_o, mret);
    chk({tag, " full R4"}, full_o, mcnt == D);
    chk({tag, " empty R4"}, empty_o, mcnt == 0);
    chk({tag, " overflow R5"}, overflow_o, movf);
    chk({tag, " underflow R6"}, underflow_o, munf);
    chk({tag, " collide R7"}, collide_o, mcol);
  endtask

  task automatic do_reset();
    rst_n = 0; call_i = 0; ret_i = 0; irq_req_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mwp = 0; mcnt = 0; mret = '0; movf = 0; munf = 0; mcol = 0;
    foreach (mm[i]) mm[i] = '0;
  endtask

  // One cycle: drive at negedge, check ack, advance model, check state at next negedge.
  task automatic step(string tag, bit c, bit r, bit q, logic [W-1:0] a);
    bit ea, push;
    call_i = c; ret_i = r; irq_req_i = q; ret_pc_i = a;
    #1;
    ea = exp_ack(c, r, q, mcnt);
    chk({tag, " ack R3"}, irq_ack_o, ea);
    push = c || ea;
    if (push) begin
      mm[mwp] = a; mwp = nxt(mwp);
      if (mcnt == D) movf = 1; else mcnt++;
      if (r) mcol = 1;
    end else if (r) begin
      if (mcnt == 0) munf = 1;
      else begin mwp = prv(mwp); mcnt--; mret = mm[mwp]; end
    end
    @(negedge clk);
    chk_state(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    #1;
    chk_state("R1 reset");

    // R2: LIFO order
    for (int i = 0; i < 3; i++) step("R2 push", 1, 0, 0, W'(12'h100 + i));
    for (int i = 0; i < 3; i++) step("R2 pop", 0, 1, 0, '0);
    chk("R2 last pop", ret_addr_o, 12'h100);

    // R3/R4/R8: fill via acknowledges, then hold back, then release
    for (int i = 0; i < D; i++) step("R3 ack fill", 0, 0, 1, W'(12'h200 + i));
    chk("R4 full after fill", full_o, 1);
    step("R3 held while full", 0, 0, 1, 12'h2ff);
    step("R8 pop frees level", 0, 1, 1, '0);
    chk("R8 pop value", ret_addr_o, 12'h207);
    step("R8 ack after pop", 0, 0, 1, 12'h2aa);
    chk("R8 full again", full_o, 1);

    // R5: call while full wraps
    step("R5 call full", 1, 0, 0, 12'h3c3);
    chk("R5 overflow set", overflow_o, 1);
    for (int i = 0; i < D; i++) step("R5 drain", 0, 1, 0, '0);
    chk("R5 oldest overwritten", ret_addr_o, 12'h201);

    // R6: pop while empty
    step("R6 pop empty", 0, 1, 0, '0);
    chk("R6 addr kept", ret_addr_o, 12'h201);

    // R7: push and pop together
    step("R7 prep", 1, 0, 0, 12'h055);
    step("R7 clash", 1, 1, 1, 12'h066);
    chk("R7 two held", empty_o, 0);
    step("R7 pop", 0, 1, 0, '0);
    chk("R7 pushed value kept", ret_addr_o, 12'h066);

    // Random phase with varying density
    do_reset();
    #1;
    chk_state("R1 reset again");
    for (int i = 0; i < 3000; i++) begin
      int bias = (i / 300) % 3;
      int pc = (bias == 0) ? 60 : (bias == 1) ? 25 : 40;
      bit c = ($urandom % 100) < pc;
      bit r = ($urandom % 100) < (70 - pc);
      bit q = ($urandom % 100) < 30;
      step("R2 random", c, r, q, W'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule